// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear Option

The block guards a processor core against runaway software. A counter advances on a selected time base. If software fails to service it before the count runs out, the block raises a reset request. The time base is fixed by a static option. It is either a slow free-running tick, supplied by an external oscillator model, or the instruction clock, which is the system clock divided by four. A base stage of 2^BASE_W counts feeds a prescaler. A 3-bit select sets the prescaler ratio to 1, 2, 4 and so on up to 128.

Software services the counter with clear strobes. In single-clear mode one strobe is enough. In paired-clear mode two distinct strobes must both arrive, in either order, before the counter clears. A halt instruction and the external reset also clear the counter. On overflow the block reports a time-out. The kind of reset it requests depends on the core's state: a full chip reset during normal run, and a warm reset, which restarts only the program counter and stack pointer, while the core is halted. A static enable option can switch the whole block off.

Top module: `wdog_guard`

## Requirements
- R1: With `src_sel`=1 the counter advances once per cycle in which `slow_tick` is high. With `src_sel`=0 it advances once every fourth `clk` cycle, the first advance falling on the fourth edge after reset, and `slow_tick` is ignored.
- R2: After a clear, the overflow happens on advance number 2^BASE_W × 2^`pre_sel`, and on no earlier advance.
- R3: With `wdt_en`=0 no output ever pulses, and clears and halts have no effect.
- R4: A high `rst`, a `halt_cmd` strobe or an accepted software clear returns the counter to zero. A clear beats an advance that arrives in the same cycle.
- R5: With `dual_clr`=0 a `clr_one` strobe clears the counter, and `clr_a` and `clr_b` are ignored.
- R6: With `dual_clr`=1 the counter clears only once both `clr_a` and `clr_b` have been seen, in either order or in the same cycle. A repeat of the same strobe does not stand in for the other, and `clr_one` is ignored. Every clear or overflow forgets any strobe seen so far.
- R7: An overflow while `halted`=0 gives a one-cycle pulse on `chip_rst_req` and on `timeout_evt` in the cycle after the final advance. `warm_rst_req` stays low.
- R8: An overflow while `halted`=1 gives a one-cycle pulse on `warm_rst_req` and on `timeout_evt`. `chip_rst_req` stays low.
- R9: With `src_sel`=0 no advance happens while `halted`=1. Counting resumes where it stopped once `halted` falls.
- R10: After an overflow the counter restarts from zero, and the next overflow needs a full period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high external reset |
| wdt_en | input | 1 | Static enable option |
| src_sel | input | 1 | Static time base option: 1 slow tick, 0 instruction clock |
| dual_clr | input | 1 | Static option: 1 paired-clear mode, 0 single-clear mode |
| pre_sel | input | 3 | Static prescaler select, ratio 2^pre_sel |
| slow_tick | input | 1 | One-cycle enable from the slow oscillator model |
| clr_one | input | 1 | Strobe: single-mode clear instruction executed |
| clr_a | input | 1 | Strobe: first paired clear instruction executed |
| clr_b | input | 1 | Strobe: second paired clear instruction executed |
| halt_cmd | input | 1 | Strobe: halt instruction executed |
| halted | input | 1 | Level: core is in the halt state |
| chip_rst_req | output | 1 | Pulse: full chip reset request |
| warm_rst_req | output | 1 | Pulse: warm reset request |
| timeout_evt | output | 1 | Pulse: time-out occurred |

## Verification
The assertions assume that the option inputs `wdt_en`, `src_sel`, `dual_clr` and `pre_sel` stay fixed outside reset. They also assume that the clear and halt inputs are single-cycle strobes. The stimulus changes options only while `rst` is high, and it raises every strobe for exactly one cycle. The `halted` level is set before a run begins and held for that run. The only exception is the resume test for the instruction clock, where `halted` falls once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    SRC_INSN = 1'b0,
    SRC_SLOW = 1'b1
  } wd_src_e;

  localparam int WD_SEL_W = 3;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
  import wdog_pkg::*;
#(
  parameter int INSN_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic src_sel,
  input  logic slow_tick,
  input  logic halted,
  output logic tick
);
  localparam int PH_W = (INSN_DIV > 1) ? $clog2(INSN_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSN_DIV - 1);

  logic [PH_W-1:0] phase;
  logic            insn_tick;

  // instruction clock phase stops with the system clock during halt
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (!halted) begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign insn_tick = (phase == PH_LAST) && !halted;

  always_comb begin
    if (wd_src_e'(src_sel) == SRC_SLOW) tick = slow_tick;
    else                                tick = insn_tick;
  end

  AST_INSN_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (halted && !src_sel) |=> $stable(phase)); // R9
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dual,
  input  logic clr_one,
  input  logic clr_a,
  input  logic clr_b,
  input  logic other_clr,
  output logic clr_ok
);
  logic seen_a, seen_b;

  always_comb begin
    if (!en)       clr_ok = 1'b0;
    else if (dual) clr_ok = (clr_a || seen_a) && (clr_b || seen_b);
    else           clr_ok = clr_one;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_ok || other_clr) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else if (en && dual) begin
      seen_a <= seen_a || clr_a;
      seen_b <= seen_b || clr_b;
    end
  end

  AST_ARMS_DROP: assert property (@(posedge clk) disable iff (rst)
    clr_ok |=> (!seen_a && !seen_b)); // R6
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int BASE_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             wrap
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [BASE_W-1:0] base_cnt;
  logic [PRE_W-1:0]  pre_cnt;
  logic [PRE_W-1:0]  pre_lim;
  logic              base_full;
  logic              pre_full;

  assign pre_lim   = {PRE_W{1'b1}} >> (PRE_W - int'(sel));
  assign base_full = &base_cnt;
  assign pre_full  = (pre_cnt == pre_lim);
  assign wrap      = tick && base_full && pre_full && !clear;

  always_ff @(posedge clk) begin
    if (clear) begin
      base_cnt <= '0;
      pre_cnt  <= '0;
    end else if (tick) begin
      base_cnt <= base_cnt + 1'b1;
      if (base_full) pre_cnt <= pre_full ? '0 : pre_cnt + 1'b1;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (base_cnt == '0 && pre_cnt == '0)); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!clear && !tick) |=> ($stable(base_cnt) && $stable(pre_cnt))); // R2
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_W   = 16,
  parameter int INSN_DIV = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wdt_en,
  input  logic                src_sel,
  input  logic                dual_clr,
  input  logic [WD_SEL_W-1:0] pre_sel,
  input  logic                slow_tick,
  input  logic                clr_one,
  input  logic                clr_a,
  input  logic                clr_b,
  input  logic                halt_cmd,
  input  logic                halted,
  output logic                chip_rst_req,
  output logic                warm_rst_req,
  output logic                timeout_evt
);
  logic tick, clr_ok, wrap, cnt_clear;

  wdog_tick_sel #(.INSN_DIV(INSN_DIV)) u_tick (
    .clk(clk), .rst(rst), .src_sel(src_sel), .slow_tick(slow_tick),
    .halted(halted), .tick(tick)
  );

  wdog_clear_ctl u_clr (
    .clk(clk), .rst(rst), .en(wdt_en), .dual(dual_clr),
    .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b),
    .other_clr(halt_cmd || wrap), .clr_ok(clr_ok)
  );

  // a disabled watchdog is held at zero, so it can never wrap
  assign cnt_clear = rst || !wdt_en || clr_ok || halt_cmd;

  wdog_divider #(.BASE_W(BASE_W), .SEL_W(WD_SEL_W)) u_div (
    .clk(clk), .rst(rst), .clear(cnt_clear), .tick(tick),
    .sel(pre_sel), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_rst_req <= 1'b0;
      warm_rst_req <= 1'b0;
      timeout_evt  <= 1'b0;
    end else begin
      chip_rst_req <= wrap && !halted;
      warm_rst_req <= wrap && halted;
      timeout_evt  <= wrap;
    end
  end

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> !timeout_evt); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> !timeout_evt); // R10
endmodule

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
  localparam int BW = 4;
  localparam int N  = 1 << BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wdt_en = 1'b1, src_sel = 1'b1, dual_clr = 1'b0, halted = 1'b0;
  logic [2:0] pre_sel = 3'd0;
  logic slow_tick = 1'b0, clr_one = 1'b0, clr_a = 1'b0, clr_b = 1'b0, halt_cmd = 1'b0;
  logic chip_rst_req, warm_rst_req, timeout_evt;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_guard #(.BASE_W(BW)) i_wdog_guard (
    .clk(clk), .rst(rst), .wdt_en(wdt_en), .src_sel(src_sel), .dual_clr(dual_clr),
    .pre_sel(pre_sel), .slow_tick(slow_tick), .clr_one(clr_one), .clr_a(clr_a),
    .clr_b(clr_b), .halt_cmd(halt_cmd), .halted(halted),
    .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .timeout_evt(timeout_evt)
  );

  // entry: {dual, halted, sel[2:0], exp_chip, exp_warm}
  localparam logic [6:0] VEC [5] = '{
    7'b0_0_000_1_0, 7'b1_1_001_0_1, 7'b0_0_011_1_0, 7'b1_0_101_1_0, 7'b0_1_111_0_1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic tick1();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  task automatic ticks_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick1();
      if (timeout_evt || chip_rst_req || warm_rst_req) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic expect_to(input string req);
    tick1();
    chk(timeout_evt && chip_rst_req && !warm_rst_req, req,
        {timeout_evt, chip_rst_req, warm_rst_req}, 3'b110);
  endtask

  task automatic strobe(input int which);
    case (which)
      0: clr_one = 1'b1;
      1: clr_a = 1'b1;
      2: clr_b = 1'b1;
      3: begin clr_a = 1'b1; clr_b = 1'b1; end
      default: halt_cmd = 1'b1;
    endcase
    @(negedge clk);
    clr_one = 1'b0; clr_a = 1'b0; clr_b = 1'b0; halt_cmd = 1'b0;
  endtask

  task automatic first_to(input int lim, output int at);
    at = 0;
    for (int c = 1; c <= lim; c++) begin
      @(negedge clk);
      if (timeout_evt && at == 0) at = c;
    end
  endtask

  initial begin
    int at;
    @(negedge clk);
    do_reset();
    chk(!chip_rst_req && !warm_rst_req && !timeout_evt, "R7 reset state",
        {chip_rst_req, warm_rst_req, timeout_evt}, 0);

    // vector table: period and reset kind per prescaler/halt setting
    for (int v = 0; v < 5; v++) begin
      rst = 1'b1;
      dual_clr = VEC[v][6]; halted = VEC[v][5]; pre_sel = VEC[v][4:2];
      do_reset();
      ticks_quiet((N << VEC[v][4:2]) - 1, "R2 early");
      tick1();
      chk(timeout_evt, "R2 period", timeout_evt, 1);
      chk(chip_rst_req == VEC[v][1], "R7 chip kind", chip_rst_req, VEC[v][1]);
      chk(warm_rst_req == VEC[v][0], "R8 warm kind", warm_rst_req, VEC[v][0]);
    end
    rst = 1'b1; halted = 1'b0; pre_sel = 3'd0; dual_clr = 1'b0;

    // R5 single clear
    do_reset();
    ticks_quiet(N - 1, "R5"); strobe(0);
    ticks_quiet(N - 1, "R5 cleared"); expect_to("R5 period after clear");
    ticks_quiet(10, "R5"); strobe(1); strobe(2);
    ticks_quiet(N - 11, "R5"); expect_to("R5 paired strobes ignored");
    // R10 restart
    ticks_quiet(N - 1, "R10"); expect_to("R10 second overflow");

    // R4 halt clears, clear beats tick
    ticks_quiet(N - 1, "R4"); strobe(4);
    ticks_quiet(N - 1, "R4 halt"); expect_to("R4 halt clear");
    ticks_quiet(N - 1, "R4");
    clr_one = 1'b1; slow_tick = 1'b1; @(negedge clk); clr_one = 1'b0; slow_tick = 1'b0;
    chk(!timeout_evt, "R4 clear wins", timeout_evt, 0);
    ticks_quiet(N - 1, "R4"); expect_to("R4 restart after clear");

    // R6 paired clear
    rst = 1'b1; dual_clr = 1'b1;
    do_reset();
    ticks_quiet(10, "R6"); strobe(1); strobe(1); strobe(0);
    ticks_quiet(N - 11, "R6"); expect_to("R6 repeat and single ignored");
    ticks_quiet(10, "R6"); strobe(2); ticks_quiet(3, "R6"); strobe(1);
    ticks_quiet(N - 1, "R6 b then a"); expect_to("R6 pair clears");
    ticks_quiet(8, "R6"); strobe(3);
    ticks_quiet(N - 1, "R6 same cycle"); expect_to("R6 same-cycle pair");
    ticks_quiet(4, "R6"); strobe(1); strobe(2);
    ticks_quiet(4, "R6"); strobe(2);
    ticks_quiet(N - 5, "R6"); expect_to("R6 arms forgotten");

    // R3 disabled
    rst = 1'b1; wdt_en = 1'b0; dual_clr = 1'b0;
    do_reset();
    strobe(0); strobe(4);
    ticks_quiet(3 * N, "R3 disabled");
    rst = 1'b1; wdt_en = 1'b1;

    // R1 instruction clock, slow tick ignored
    src_sel = 1'b0; slow_tick = 1'b1;
    do_reset();
    first_to(4 * N + 8, at);
    chk(at == 4 * N, "R1 insn clock period", at, 4 * N);

    // R9 halted instruction clock
    rst = 1'b1; halted = 1'b1; slow_tick = 1'b0;
    do_reset();
    first_to(8 * N, at);
    chk(at == 0, "R9 stopped in halt", at, 0);
    halted = 1'b0;
    first_to(4 * N + 8, at);
    chk(at == 4 * N, "R9 resume", at, 4 * N);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule